// File: doc/BRIEF.md
# BCD Calendar Counter with Frozen Host Copy

This block keeps the time of day and the calendar date in packed BCD: seconds, minutes, hours, day of week, date, month, year and century. It advances on a one-clock-wide `tick` input that arrives once per second. An upstream prescaler makes that tick; this block does not.

Two register sets hold the time. The working set counts on every tick while counting is enabled. The host-visible copy follows the working set when the host has enabled updates. A host uses a byte-wide port to freeze the host copy, which makes a multi-byte read consistent. The host can also write a new time into the frozen copy and then hand it to the working set in a single step. Reads are combinational from the host copy. Writes take effect at the next clock edge.

Addresses 0 to 7 are the time fields. Address 8 is the control register. All other addresses read as zero.

Top module: `bcd_calendar`

## Requirements
- R1: The time fields are at these addresses: seconds 0, minutes 1, hours 2, day of week 3, date 4, month 5, year 6 and century 7. Month bit 7 is the stop bit. Written values are masked, so unused bits read 0. The masks are 7Fh for seconds and minutes, 3Fh for hours, date and century, 07h for day of week, 1Fh for the month value and FFh for the year. The control register is at address 8, and its bit 0 is the update-enable bit. Every other address reads 00h.
- R2: After reset the block reads century 20h, year 00h, month 01h, date 01h, day of week 01h, and 00h for hours, minutes and seconds. The update-enable bit reads 1 and the stop bit reads 0.
- R3: Seconds and minutes count 00 to 59 and wrap to 00 with a carry. Hours count 00 to 23 and wrap to 00 with a carry into the day.
- R4: Each day rollover does three things. The day of week advances and goes from 7 back to 1. The date goes from the last day of the month to 01 and increments the month. The month goes from 12 to 01 and increments the year.
- R5: February has 29 days when the year is divisible by 4, and year 00 counts as divisible. Otherwise February has 28 days. Months 04, 06, 09 and 11 have 30 days, and every other month has 31.
- R6: Year 99 wraps to 00 and increments the century. Century 39 wraps to 00.
- R7: While update-enable is 1 and the count is running, each tick loads the host copy with the new count. The new value is readable in the cycle after the tick edge.
- R8: Writing 0 to update-enable freezes the host copy at its current value. A tick in the same cycle as that write does not reach the host copy. The working set keeps counting while the copy is frozen. Writing 1 afterwards with no time writes leaves the working set unchanged, and the host copy catches up on the next tick.
- R9: While the copy is frozen, time writes land in the host copy. A later write of 1 to update-enable loads the whole host copy into the working set. A tick in that same cycle is discarded, and counting resumes from the loaded value on the next tick.
- R10: Time-field writes are ignored while update-enable is 1, except for the month stop bit.
- R11: Month bit 7 can be written at any time and reads back. While it is 1, ticks do not advance the working set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |

## Verification
Two functions can fall in the same cycle here. A second tick can land on the cycle where the host changes the update-enable bit, in either direction. The bench drives `tick` together with the control write: once when it freezes the copy, and once when it resumes after loading a written time.

In the freeze case, the copy must show the pre-tick seconds, and later ticks must prove that the working set took that tick. In the load case, the copy must show the written value, and one further tick must advance it by exactly one.

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter int          ADDR_W   = 4,
  parameter logic [7:0]  CEN_LAST = 8'h39,
  parameter logic [7:0]  CEN_INIT = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);

  localparam int NREG = 8;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(NREG);
  localparam logic [ADDR_W-1:0] MON_A  = ADDR_W'(5);
  localparam logic [7:0] FIELD_MASK [NREG] =
    '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF, 8'h3F};
  localparam logic [7:0] RST_VAL [NREG] =
    '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, CEN_INIT};

  logic [7:0] cur [NREG];
  logic [7:0] shd [NREG];
  logic [7:0] nxt [NREG];
  logic       xfer, stop, dirty;

  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  logic time_hit, wr_time, wr_ctrl, freeze_now, load_now, step, publish;
  assign time_hit   = addr < CTRL_A;
  assign wr_time    = wr_en && time_hit;
  assign wr_ctrl    = wr_en && (addr == CTRL_A);
  assign freeze_now = wr_ctrl && !wr_data[0];
  assign load_now   = wr_ctrl && wr_data[0] && !xfer && dirty;
  assign step       = tick && !stop && !load_now;
  assign publish    = step && xfer && !freeze_now;

  logic       leap;
  logic [7:0] mlen;
  assign leap = cur[6][4] ? (cur[6][3:0] == 4'd2 || cur[6][3:0] == 4'd6)
                          : (cur[6][3:0] == 4'd0 || cur[6][3:0] == 4'd4 || cur[6][3:0] == 4'd8);
  assign mlen = (cur[5] == 8'h02) ? (leap ? 8'h29 : 8'h28) :
                (cur[5] == 8'h04 || cur[5] == 8'h06 || cur[5] == 8'h09 || cur[5] == 8'h11) ? 8'h30 : 8'h31;

  logic wrap_s, wrap_m, wrap_h, wrap_d, wrap_mo, wrap_y;
  assign wrap_s  = cur[0] >= 8'h59;
  assign wrap_m  = wrap_s  && cur[1] >= 8'h59;
  assign wrap_h  = wrap_m  && cur[2] >= 8'h23;
  assign wrap_d  = wrap_h  && cur[4] >= mlen;
  assign wrap_mo = wrap_d  && cur[5] >= 8'h12;
  assign wrap_y  = wrap_mo && cur[6] >= 8'h99;

  assign nxt[0] = wrap_s ? 8'h00 : bcd_step(cur[0]);
  assign nxt[1] = wrap_s ? (wrap_m ? 8'h00 : bcd_step(cur[1])) : cur[1];
  assign nxt[2] = wrap_m ? (wrap_h ? 8'h00 : bcd_step(cur[2])) : cur[2];
  assign nxt[3] = wrap_h ? ((cur[3] >= 8'h07) ? 8'h01 : cur[3] + 8'd1) : cur[3];
  assign nxt[4] = wrap_h ? (wrap_d ? 8'h01 : bcd_step(cur[4])) : cur[4];
  assign nxt[5] = wrap_d ? (wrap_mo ? 8'h01 : bcd_step(cur[5])) : cur[5];
  assign nxt[6] = wrap_mo ? (wrap_y ? 8'h00 : bcd_step(cur[6])) : cur[6];
  assign nxt[7] = wrap_y ? ((cur[7] >= CEN_LAST) ? 8'h00 : bcd_step(cur[7])) : cur[7];

  always_comb begin
    rd_data = 8'h00;
    if (time_hit) rd_data = shd[addr[2:0]];
    if (addr == MON_A) rd_data[7] = stop;
    if (addr == CTRL_A) rd_data = {7'b0, xfer};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        cur[i] <= RST_VAL[i];
        shd[i] <= RST_VAL[i];
      end
      xfer  <= 1'b1;
      stop  <= 1'b0;
      dirty <= 1'b0;
    end else begin
      if (wr_en && addr == MON_A) stop <= wr_data[7];
      if (wr_time && !xfer) begin
        shd[addr[2:0]] <= wr_data & FIELD_MASK[addr[2:0]];
        dirty <= 1'b1;
      end
      if (wr_ctrl) xfer <= wr_data[0];
      if (load_now) begin
        for (int i = 0; i < NREG; i++) cur[i] <= shd[i];
        dirty <= 1'b0;
      end else if (step) begin
        for (int i = 0; i < NREG; i++) cur[i] <= nxt[i];
      end
      if (publish)
        for (int i = 0; i < NREG; i++) shd[i] <= nxt[i];
    end
  end

  logic [8*NREG-1:0] cur_flat, shd_flat;
  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign cur_flat[g*8 +: 8] = cur[g];
    assign shd_flat[g*8 +: 8] = shd[g];
  end

  // R1
  sec_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> (rd_data[7] == 1'b0));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop && !wr_ctrl && cur[0] == 8'h59) |=> (cur[0] == 8'h00));

  // R7
  live_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop && xfer && !wr_ctrl) |=> (shd_flat == cur_flat));

  // R8
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !wr_time) |=> $stable(shd_flat));

  // R11
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_ctrl) |=> $stable(cur_flat));

endmodule

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bcd_calendar u_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  // word layout: century, year, month, date, day-of-week, hour, minute, second
  localparam int NV = 17;
  localparam logic [127:0] VEC [NV] = '{
    {64'h20240315_03102030, 64'h20240315_03102031}, // R3 plain second
    {64'h20240315_03102059, 64'h20240315_03102100}, // R3
    {64'h20240315_03105959, 64'h20240315_03110000}, // R3
    {64'h20240315_03235959, 64'h20240316_04000000}, // R4
    {64'h20240310_07235959, 64'h20240311_01000000}, // R4 weekday wrap
    {64'h20230131_02235959, 64'h20230201_03000000}, // R4
    {64'h20230430_05235959, 64'h20230501_06000000}, // R5 30-day month
    {64'h20230228_02235959, 64'h20230301_03000000}, // R5 common year
    {64'h20240228_03235959, 64'h20240229_04000000}, // R5 leap
    {64'h20240229_04235959, 64'h20240301_05000000}, // R5
    {64'h21000228_01235959, 64'h21000229_02000000}, // R5 year 00
    {64'h20231231_07235959, 64'h20240101_01000000}, // R4
    {64'h20991231_04235959, 64'h21000101_05000000}, // R6
    {64'h39991231_06235959, 64'h00000101_07000000}, // R6 century wrap
    {64'h20120228_02235959, 64'h20120229_03000000}, // R5 odd tens
    {64'h20100228_07235959, 64'h20100301_01000000}, // R5
    {64'h20231130_04235959, 64'h20231201_05000000}  // R5
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic tk);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  logic [7:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    rd(4'd0, v); check("R2 sec", v, 8'h00);
    rd(4'd1, v); check("R2 min", v, 8'h00);
    rd(4'd2, v); check("R2 hour", v, 8'h00);
    rd(4'd3, v); check("R2 dow", v, 8'h01);
    rd(4'd4, v); check("R2 date", v, 8'h01);
    rd(4'd5, v); check("R2 month", v, 8'h01);
    rd(4'd6, v); check("R2 year", v, 8'h00);
    rd(4'd7, v); check("R2 century", v, 8'h20);
    rd(4'd8, v); check("R2 ctrl", v, 8'h01);

    // R10 writes ignored while live
    wr(4'd0, 8'h45, 1'b0);
    wr(4'd2, 8'h12, 1'b0);
    rd(4'd0, v); check("R10 sec", v, 8'h00);
    rd(4'd2, v); check("R10 hour", v, 8'h00);

    // R7 live follow
    repeat (3) pulse();
    rd(4'd0, v); check("R7 sec", v, 8'h03);

    // R8 freeze with colliding tick
    wr(4'd8, 8'h00, 1'b1);
    rd(4'd0, v); check("R8 frozen at collision", v, 8'h03);
    repeat (2) pulse();
    rd(4'd0, v); check("R8 frozen hold", v, 8'h03);
    wr(4'd8, 8'h01, 1'b0);
    rd(4'd0, v); check("R8 clean resume no load", v, 8'h03);
    pulse();
    rd(4'd0, v); check("R8 catch-up", v, 8'h07);

    // R9 load with colliding tick
    wr(4'd8, 8'h00, 1'b0);
    wr(4'd0, 8'h10, 1'b0);
    wr(4'd8, 8'h01, 1'b1);
    rd(4'd0, v); check("R9 loaded", v, 8'h10);
    pulse();
    rd(4'd0, v); check("R9 tick discarded", v, 8'h11);
    rd(4'd1, v); check("R9 min", v, 8'h00);

    // R11 stop bit
    wr(4'd5, 8'h81, 1'b0);
    rd(4'd5, v); check("R11 stop readback", v, 8'h81);
    repeat (3) pulse();
    rd(4'd0, v); check("R11 stopped", v, 8'h11);
    wr(4'd5, 8'h00, 1'b0);
    rd(4'd5, v); check("R11 stop cleared", v, 8'h01);
    pulse();
    rd(4'd0, v); check("R11 running", v, 8'h12);

    // R1 masks
    wr(4'd8, 8'h00, 1'b0);
    for (int i = 0; i < 8; i++) wr(4'(i), 8'hFF, 1'b0);
    rd(4'd0, v); check("R1 sec mask", v, 8'h7F);
    rd(4'd1, v); check("R1 min mask", v, 8'h7F);
    rd(4'd2, v); check("R1 hour mask", v, 8'h3F);
    rd(4'd3, v); check("R1 dow mask", v, 8'h07);
    rd(4'd4, v); check("R1 date mask", v, 8'h3F);
    rd(4'd5, v); check("R1 month mask", v, 8'h9F);
    rd(4'd6, v); check("R1 year mask", v, 8'hFF);
    rd(4'd7, v); check("R1 century mask", v, 8'h3F);
    rd(4'd8, v); check("R1 ctrl frozen", v, 8'h00);
    rd(4'd9, v); check("R1 unused addr", v, 8'h00);
    wr(4'd5, 8'h01, 1'b0);

    // table: load start time, one tick, compare
    for (int n = 0; n < NV; n++) begin
      wr(4'd8, 8'h00, 1'b0);
      for (int i = 0; i < 8; i++) wr(4'(i), VEC[n][64 + i*8 +: 8], 1'b0);
      wr(4'd8, 8'h01, 1'b0);
      pulse();
      for (int i = 0; i < 8; i++) begin
        rd(4'(i), v);
        check($sformatf("R3/R4/R5/R6/R9 vec %0d reg %0d", n, i), v, VEC[n][i*8 +: 8]);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule